// File: doc/BRIEF.md
# Configurable-Precision Complex Multiply-Accumulate Lane

This block is one slice of a wide SIMD multiply-accumulate datapath. Each operation reads two 80-bit operand words, a data word A and a coefficient word B, and a 160-bit accumulator word. The accumulator word holds four 40-bit accumulator lanes. An opcode tells the slice how to read the operand words:

- four 20-bit real elements,
- two complex pairs of 20+20 bits,
- two 40-bit real elements, or
- one complex pair of 40+40 bits.

Every 20-bit position owns two signed 18x18 multipliers. In real modes a position forms one real product. In complex modes a position forms half of a complex product. Before multiplication every operand element is cut down to its top 18 bits. Each 36-bit product is sign-extended to 40 bits, and may then be added into its accumulator lane. The 40-bit lanes keep guard bits above the memory precision, so long sums stay accurate.

The arithmetic has two register stages. The first stage holds the eight raw products. The second stage holds the combined and accumulated result. A valid strobe travels with the data, and one result appears two cycles after each accepted input. Inputs may be issued back-to-back, one per cycle.

Top module: `cmac_lane`

## Requirements
- R1: After reset, `out_valid` is 0 and `acc_out` is all zeros.
- R2: `out_valid` is high in exactly the cycle that comes two rising edges after a cycle with `in_valid` high. Inputs issued on consecutive cycles give results on consecutive cycles, in the same order.
- R3: While `out_valid` is low, `acc_out` keeps its previous value.
- R4: Narrow real mode (`op[0]`=0, `op[2]`=0). Lane k is `acc_out[40k+39:40k]`. It takes the product of the top 18 bits (bits 19:2) of 20-bit element k of A (`opa[20k+19:20k]`) and the matching element of B, sign-extended to 40 bits. The two low bits of each element have no effect.
- R5: Narrow complex mode (`op[0]`=1, `op[2]`=0). Pair j uses element 2j as the real part and element 2j+1 as the imaginary part. Lane 2j = ar*br − ai*bi and lane 2j+1 = ar*bi + ai*br.
- R6: The conjugate bit (`op[1]`=1) in a complex mode replaces B's imaginary part with its negation. The real part becomes ar*br + ai*bi and the imaginary part becomes ai*br − ar*bi.
- R7: Wide real mode (`op[0]`=0, `op[2]`=1). Lane e (e = 0, 1) is the product of the top 18 bits (bits 40e+39:40e+22) of 40-bit element e of A and B. Lanes 2 and 3 of `acc_out` are copied unchanged from `acc_in`.
- R8: Wide complex mode (`op[0]`=1, `op[2]`=1). The real part is bits 39:0 and the imaginary part is bits 79:40, each cut to its top 18 bits. Lane 0 receives the real result and lane 1 the imaginary result. Lanes 2 and 3 are copied from `acc_in`.
- R9: With `op[3]`=1, each computed lane adds its result to the matching `acc_in` lane, wrapping modulo 2^40 with no saturation. With `op[3]`=0, the result replaces the lane.
- R10: In real modes the conjugate bit `op[1]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request for this cycle |
| op | input | 4 | [0] complex, [1] conjugate, [2] 40-bit elements, [3] accumulate |
| opa | input | 80 | Data operand word A |
| opb | input | 80 | Coefficient operand word B |
| acc_in | input | 160 | Four 40-bit accumulator lanes, lane k at bits 40k+39:40k |
| out_valid | output | 1 | Result present on acc_out |
| acc_out | output | 160 | Updated accumulator lanes |

## Verification
The hardest situation to reach is an accumulator lane that wraps through 2^40. Products are at most about 2^34, so ordinary stimulus never gets near the limit. The bench therefore loads `acc_in` directly with a lane just below the positive limit and accumulates a positive product. It then checks that the sign bit flips with no clamping. A second hard case is a mix of extreme operands (−2^17 in every slot) with the conjugate sign change. Back-to-back issue with changing modes shows that opcode and data stay aligned through both stages.

// File: rtl/cmac_lane.sv
module cmac_lane #(
  parameter int EW = 20,
  parameter int MW = 18,
  parameter int AW = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [4*EW-1:0]   opa,
  input  logic [4*EW-1:0]   opb,
  input  logic [4*AW-1:0]   acc_in,
  output logic              out_valid,
  output logic [4*AW-1:0]   acc_out
);
  localparam int WW = 2*EW;
  localparam int PW = 2*MW;
  localparam int LW = 4*AW;

  logic signed [MW-1:0] na [4];
  logic signed [MW-1:0] nb [4];
  logic signed [MW-1:0] wa [2];
  logic signed [MW-1:0] wb [2];
  logic signed [MW-1:0] ma [4][2];
  logic signed [MW-1:0] mb [4][2];
  logic signed [PW-1:0] prod [4][2];
  logic signed [PW-1:0] p1 [4][2];
  logic [LW-1:0] acc1;
  logic [3:0]    op1;
  logic          v1;
  logic [LW-1:0] nxt;

  wire cplx = op[0];
  wire wide = op[2];

  for (genvar k = 0; k < 4; k++) begin : g_nsel
    assign na[k] = opa[EW*k+EW-1 -: MW];
    assign nb[k] = opb[EW*k+EW-1 -: MW];
  end
  for (genvar e = 0; e < 2; e++) begin : g_wsel
    assign wa[e] = opa[WW*e+WW-1 -: MW];
    assign wb[e] = opb[WW*e+WW-1 -: MW];
  end

  always_comb begin
    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 2; m++) begin
        ma[k][m] = '0;
        mb[k][m] = '0;
      end
    if (!cplx) begin
      for (int k = 0; k < 4; k++) begin
        if (!wide) begin
          ma[k][0] = na[k];
          mb[k][0] = nb[k];
        end else if (k < 2) begin
          ma[k][0] = wa[k];
          mb[k][0] = wb[k];
        end
      end
    end else begin
      for (int j = 0; j < 2; j++) begin
        if (!wide || j == 0) begin
          ma[2*j][0]   = wide ? wa[0] : na[2*j];
          mb[2*j][0]   = wide ? wb[0] : nb[2*j];
          ma[2*j][1]   = wide ? wa[1] : na[2*j+1];
          mb[2*j][1]   = wide ? wb[1] : nb[2*j+1];
          ma[2*j+1][0] = wide ? wa[0] : na[2*j];
          mb[2*j+1][0] = wide ? wb[1] : nb[2*j+1];
          ma[2*j+1][1] = wide ? wa[1] : na[2*j+1];
          mb[2*j+1][1] = wide ? wb[0] : nb[2*j];
        end
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_pos
    for (genvar m = 0; m < 2; m++) begin : g_mul
      assign prod[k][m] = ma[k][m] * mb[k][m];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      op1  <= '0;
      acc1 <= '0;
      for (int k = 0; k < 4; k++)
        for (int m = 0; m < 2; m++)
          p1[k][m] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        op1  <= op;
        acc1 <= acc_in;
        for (int k = 0; k < 4; k++)
          for (int m = 0; m < 2; m++)
            p1[k][m] <= prod[k][m];
      end
    end
  end

  function automatic logic [AW-1:0] sx(input logic [PW-1:0] p);
    return {{(AW-PW){p[PW-1]}}, p};
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [AW-1:0] t0, t1, t, base;
      t0   = sx(p1[k][0]);
      t1   = sx(p1[k][1]);
      base = op1[3] ? acc1[AW*k +: AW] : '0;
      if (!op1[0])
        t = t0;
      else if (k % 2 == 0)
        t = op1[1] ? t0 + t1 : t0 - t1;
      else
        t = op1[1] ? t1 - t0 : t0 + t1;
      if (!op1[2] || k < 2)
        nxt[AW*k +: AW] = base + t;
      else
        nxt[AW*k +: AW] = acc1[AW*k +: AW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) acc_out <= nxt;
    end
  end

  // R2
  latency_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R2
  latency_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(acc_out));

  // R7
  wide_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && op1[2]) |=> acc_out[LW-1:2*AW] == $past(acc1[LW-1:2*AW]));

  // R4
  real_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && op1 == 4'b0000) |=>
      (acc_out[AW-1:PW-1] == '0 || acc_out[AW-1:PW-1] == '1));
endmodule

// File: tb/cmac_lane_bench.sv
module cmac_lane_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [3:0] op = 0;
  logic [79:0] opa = 0, opb = 0;
  logic [159:0] acc_in = 0;
  logic out_valid;
  logic [159:0] acc_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rs = 32'h1234_5678;

  always #2 clk = ~clk;

  cmac_lane u_cmac_lane (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .acc_in(acc_in), .out_valid(out_valid), .acc_out(acc_out));

  function automatic longint nel(input logic [79:0] x, input int i);
    logic signed [17:0] t;
    t = x[20*i+19 -: 18];
    return longint'(t);
  endfunction
  function automatic longint wel(input logic [79:0] x, input int e);
    logic signed [17:0] t;
    t = x[40*e+39 -: 18];
    return longint'(t);
  endfunction

  function automatic logic [159:0] model(input logic [3:0] o, input logic [79:0] a,
      input logic [79:0] b, input logic [159:0] acc);
    longint term [4];
    bit act [4];
    logic [159:0] r;
    for (int k = 0; k < 4; k++) begin term[k] = 0; act[k] = 0; end
    if (!o[0]) begin
      for (int k = 0; k < 4; k++)
        if (!o[2]) begin term[k] = nel(a,k)*nel(b,k); act[k] = 1; end
        else if (k < 2) begin term[k] = wel(a,k)*wel(b,k); act[k] = 1; end
    end else begin
      for (int j = 0; j < (o[2] ? 1 : 2); j++) begin
        longint ar, ai, br, bi;
        ar = o[2] ? wel(a,0) : nel(a,2*j);
        ai = o[2] ? wel(a,1) : nel(a,2*j+1);
        br = o[2] ? wel(b,0) : nel(b,2*j);
        bi = o[2] ? wel(b,1) : nel(b,2*j+1);
        if (o[1]) bi = -bi;
        term[2*j] = ar*br - ai*bi;
        term[2*j+1] = ar*bi + ai*br;
        act[2*j] = 1; act[2*j+1] = 1;
      end
    end
    for (int k = 0; k < 4; k++) begin
      logic [39:0] base, tt;
      base = acc[40*k +: 40];
      tt = term[k][39:0];
      if (!act[k]) r[40*k +: 40] = base;
      else r[40*k +: 40] = (o[3] ? base : 40'd0) + tt;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [159:0] got, input logic [159:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] nxt_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic run_op(input string req, input logic [3:0] o, input logic [79:0] a,
      input logic [79:0] b, input logic [159:0] acc);
    logic [159:0] exp;
    exp = model(o, a, b, acc);
    @(negedge clk);
    in_valid = 1; op = o; opa = a; opb = b; acc_in = acc;
    @(negedge clk);
    in_valid = 0; op = 4'hF; opa = '1; opb = '1; acc_in = '1;
    chk({req, " R2 early"}, {159'd0, out_valid}, 160'd0);
    @(negedge clk);
    chk({req, " R2 valid"}, {159'd0, out_valid}, 160'd1);
    chk(req, acc_out, exp);
    @(negedge clk);
    chk({req, " R3 idle valid"}, {159'd0, out_valid}, 160'd0);
    chk({req, " R3 hold"}, acc_out, exp);
  endtask

  task automatic t_reset;
    chk("R1 valid", {159'd0, out_valid}, 160'd0);
    chk("R1 acc", acc_out, 160'd0);
  endtask

  task automatic t_narrow_real;
    logic [79:0] a, b;
    a = {20'h7FFFF, 20'hFFFFC, 20'h00003, 20'h00004};
    b = {20'h7FFFF, 20'h00008, 20'h00008, 20'h00008};
    run_op("R4 narrow real", 4'b0000, a, b, '1);
    chk("R4 literal", acc_out, {40'h03_FFFC_0001, 40'hFF_FFFF_FFFE, 40'h0, 40'h2});
  endtask

  task automatic t_accum_wrap;
    logic [79:0] a, b;
    logic [159:0] acc;
    a = {20'h0, 20'h0, 20'h0, 20'h00004};
    b = {20'h0, 20'h0, 20'h0, 20'h00008};
    acc = {40'h12, 40'h34, 40'h56, 40'h7F_FFFF_FFFF};
    run_op("R9 wrap", 4'b1000, a, b, acc);
    chk("R9 wrap literal", acc_out, {40'h12, 40'h34, 40'h56, 40'h80_0000_0001});
  endtask

  task automatic t_complex;
    logic [79:0] a, b;
    a = {20'h00010, 20'hFFFF0, 20'h7FFFF, 20'h80000};
    b = {20'h80000, 20'h80000, 20'h00024, 20'hFFFE8};
    run_op("R5 narrow complex", 4'b0001, a, b, 160'h5);
    run_op("R6 narrow conj", 4'b0011, a, b, 160'h5);
    run_op("R6 conj accumulate", 4'b1011, a, b, {4{40'h00_1000_0000}});
  endtask

  task automatic t_wide;
    logic [79:0] a, b;
    logic [159:0] acc;
    a = {40'h80000_00000, 40'h12345_FFFFF};
    b = {40'h7FFFF_FFFFF, 40'hFFFC0_00000};
    acc = {40'hAA_BBCC_DDEE, 40'h11_2233_4455, 40'h1, 40'h2};
    run_op("R7 wide real", 4'b0100, a, b, acc);
    run_op("R8 wide complex", 4'b0101, a, b, acc);
    run_op("R8 wide conj acc", 4'b1111, a, b, acc);
  endtask

  task automatic t_conj_ignored;
    logic [79:0] a, b;
    a = {20'h12345, 20'hABCDE, 20'h54321, 20'hEDCBA};
    b = {20'hFEDCB, 20'h01234, 20'h80000, 20'h7FFFF};
    run_op("R10 conj in narrow real", 4'b0010, a, b, 160'h0);
    chk("R10 same as plain", acc_out, model(4'b0000, a, b, 160'h0));
    run_op("R10 conj in wide real", 4'b0110, a, b, '1);
    chk("R10 wide same as plain", acc_out, model(4'b0100, a, b, '1));
  endtask

  task automatic t_back_to_back;
    logic [3:0] o [3];
    logic [79:0] a [3], b [3];
    logic [159:0] c [3];
    for (int i = 0; i < 3; i++) begin
      rs = nxt_rand(rs); a[i][31:0] = rs; rs = nxt_rand(rs); a[i][63:32] = rs;
      rs = nxt_rand(rs); a[i][79:64] = rs[15:0]; b[i] = {a[i][39:0], a[i][79:40]} ^ {3{rs[26:0]}};
      rs = nxt_rand(rs); c[i] = {5{rs}};
    end
    o[0] = 4'b0001; o[1] = 4'b1100; o[2] = 4'b1011;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; op = o[i]; opa = a[i]; opb = b[i]; acc_in = c[i];
      if (i == 2) begin
        chk("R2 b2b valid0", {159'd0, out_valid}, 160'd1);
        chk("R2 b2b data0", acc_out, model(o[0], a[0], b[0], c[0]));
      end
      @(negedge clk);
    end
    in_valid = 0;
    chk("R2 b2b data1", acc_out, model(o[1], a[1], b[1], c[1]));
    @(negedge clk);
    chk("R2 b2b data2", acc_out, model(o[2], a[2], b[2], c[2]));
    @(negedge clk);
    chk("R2 b2b end", {159'd0, out_valid}, 160'd0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 32; i++) begin
      logic [79:0] a, b;
      logic [159:0] c;
      rs = nxt_rand(rs); a[31:0] = rs; rs = nxt_rand(rs); a[63:32] = rs;
      rs = nxt_rand(rs); a[79:64] = rs[15:0]; b[15:0] = rs[31:16];
      rs = nxt_rand(rs); b[47:16] = rs; rs = nxt_rand(rs); b[79:48] = rs;
      rs = nxt_rand(rs); c = {rs, ~rs, rs ^ 32'h5A5A5A5A, rs + 32'd7, ~rs};
      run_op($sformatf("R4 R5 R6 R7 R8 R9 sweep op %0h", i[3:0]), i[3:0], a, b, c);
    end
  endtask

  task automatic t_extremes;
    logic [79:0] m;
    m = {4{20'h80000}};
    run_op("R5 extreme", 4'b0001, m, m, '0);
    run_op("R6 extreme conj", 4'b0011, m, m, '0);
    run_op("R4 extreme real", 4'b0000, m, m, '0);
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_narrow_real();
    t_accum_wrap();
    t_complex();
    t_wide();
    t_conj_ignored();
    t_back_to_back();
    t_extremes();
    t_sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule